// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display pipe. A pixel counter runs from zero to a programmed horizontal total and then wraps, and a line counter advances on each wrap. The counts are compared against programmed start and end values. The comparisons drive registered, active-high strobes: vertical blank and vertical sync for a CRT, horizontal and vertical sync for a flat panel, and a flag that marks the visible area. Every timing value is programmed as the target count minus one. Software computes any centering offsets before it loads the registers.

In interlaced scanning the line counter advances twice per scan line, once at the middle of the line and once at its wrap. The frame then has an odd number of counter steps, so vertical sync starts mid-line in one field and at a line end in the next, and a field bit toggles on every vertical wrap. The flat-panel vertical sync is first decoded from the line count into an internal flag. That flag reaches the output only when the flat-panel horizontal sync rises. A write port loads the timing fields as a start/end pair per address, and a lock input blocks all writes.

Top module: `dtg_top`

## Requirements
- R1: While reset is asserted, every configuration field becomes zero, both counters read zero, the field bit is zero and every sync, blank and active output is low.
- R2: A write with `wrEn` high and `lock` low loads `wrStart` and `wrEnd` into the pair selected by `wrAddr` at the clock edge. The pairs are: 0 = horizontal active / horizontal total, 1 = panel hsync start / end, 2 = vertical active / vertical total, 3 = vblank start / end, 4 = vsync start / end, 5 = panel vsync start / end, and 6 = mode, where `wrStart[0]` = 1 selects interlaced scanning. The new values govern the counters from the next cycle.
- R3: A write presented while `lock` is high changes no configuration field. Counting continues with the previous values.
- R4: `hCount` advances by one each cycle and goes to 0 in the cycle after it equals or exceeds horizontal total. `vCount` steps on each line step and goes to 0 after a step taken while it equals or exceeds vertical total.
- R5: In progressive mode `vBlank` goes high the cycle after `vCount` equals blank start and low the cycle after it equals blank end. The end match wins when both match.
- R6: `vSync` goes high the cycle after `vCount` equals sync start and low the cycle after it equals sync end. The end match wins.
- R7: `fpHSync` goes high the cycle after `hCount` equals panel hsync start and low the cycle after it equals panel hsync end, so its edges can fall on any pixel. The end match wins.
- R8: An internal panel-vsync flag is set and cleared by `vCount` matching the panel vsync start / end values, which are programmed as line minus two. `fpVSync` takes the flag's value only in the cycle in which `fpHSync` rises and changes at no other time.
- R9: `active` is high in the cycle after one in which `hCount` ≤ horizontal active and `vCount` ≤ vertical active, and low otherwise.
- R10: In interlaced mode the line counter also steps when `hCount` equals horizontal total shifted right by one, unless that is also the wrap pixel. `field` toggles on each vertical wrap in interlaced mode and is cleared by a wrap in progressive mode.
- R11: In interlaced mode the vblank start / end registers are ignored. Blank starts at vertical active plus one and ends at vertical total.
- R12: In interlaced mode with an odd step count per frame, successive vertical sync rises alternate between the middle of a line and the end of a line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the timing registers |
| wrAddr | input | ADDR_W (3) | Register pair select |
| wrStart | input | CNT_W (11) | Start / active value (mode bit in bit 0) |
| wrEnd | input | CNT_W (11) | End / total value |
| lock | input | 1 | When high, all writes are dropped |
| hCount | output | CNT_W (11) | Pixel counter |
| vCount | output | CNT_W (11) | Line counter (half-line steps when interlaced) |
| field | output | 1 | Field indicator, toggles per vertical wrap when interlaced |
| vBlank | output | 1 | CRT vertical blank |
| vSync | output | 1 | CRT vertical sync |
| fpHSync | output | 1 | Flat-panel horizontal sync |
| fpVSync | output | 1 | Flat-panel vertical sync, resynchronised to fpHSync |
| active | output | 1 | Visible-area flag |

## Verification
A write lands at the clock edge that samples it. The counters move at every edge. Each blank, sync and active output is one register behind the counter values it compares, and `fpVSync` follows its internal flag only at an `fpHSync` rising edge. The bench keeps a cycle model that updates at the same rising edge as the design and compares all outputs on the following falling edge, so every result is read one half-period after the edge that produced it. Explicit checks time the vertical sync rise within the line for consecutive interlaced fields, and track every `fpVSync` change against the panel hsync edge.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int CNT_W = 11;

  localparam int ADDR_HORIZ = 0;
  localparam int ADDR_FPH   = 1;
  localparam int ADDR_VERT  = 2;
  localparam int ADDR_VBLK  = 3;
  localparam int ADDR_VSYN  = 4;
  localparam int ADDR_FPV   = 5;
  localparam int ADDR_MODE  = 6;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t hTotal;
    cnt_t hActive;
    cnt_t fhStart;
    cnt_t fhEnd;
    cnt_t vTotal;
    cnt_t vActive;
    cnt_t vbStart;
    cnt_t vbEnd;
    cnt_t vsStart;
    cnt_t vsEnd;
    cnt_t fvStart;
    cnt_t fvEnd;
    logic interlace;
  } dtg_cfg_t;

  typedef struct packed {
    logic pixWrap;
    logic lineStep;
    logic frameWrap;
  } dtg_strobe_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  cnt_t              wrStart,
  input  cnt_t              wrEnd,
  input  logic              lock,
  output dtg_cfg_t          cfg
);
  logic wrOk;
  assign wrOk = wrEn && !lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wrOk) begin
      case (int'(wrAddr))
        ADDR_HORIZ: begin cfg.hActive <= wrStart; cfg.hTotal <= wrEnd; end
        ADDR_FPH:   begin cfg.fhStart <= wrStart; cfg.fhEnd  <= wrEnd; end
        ADDR_VERT:  begin cfg.vActive <= wrStart; cfg.vTotal <= wrEnd; end
        ADDR_VBLK:  begin cfg.vbStart <= wrStart; cfg.vbEnd  <= wrEnd; end
        ADDR_VSYN:  begin cfg.vsStart <= wrStart; cfg.vsEnd  <= wrEnd; end
        ADDR_FPV:   begin cfg.fvStart <= wrStart; cfg.fvEnd  <= wrEnd; end
        ADDR_MODE:  cfg.interlace <= wrStart[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
(
  input  dtg_cfg_t    cfg,
  input  cnt_t        hCount,
  input  cnt_t        vCount,
  output dtg_strobe_t strb
);
  cnt_t hHalf;
  logic halfHit;

  assign hHalf = cfg.hTotal >> 1;

  always_comb begin
    strb.pixWrap   = hCount >= cfg.hTotal;
    halfHit        = cfg.interlace && (hCount == hHalf) && !strb.pixWrap;
    strb.lineStep  = strb.pixWrap || halfHit;
    strb.frameWrap = strb.lineStep && (vCount >= cfg.vTotal);
  end
endmodule

// File: rtl/dtg_datapath.sv
module dtg_datapath
  import dtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dtg_cfg_t    cfg,
  input  dtg_strobe_t strb,
  output cnt_t        hCount,
  output cnt_t        vCount,
  output logic        field,
  output logic        vBlank,
  output logic        vSync,
  output logic        fpHSync,
  output logic        fpVSync,
  output logic        active
);
  cnt_t blkStart, blkEnd;
  logic fpHsNext, fpVsInt;

  always_comb begin
    blkStart = cfg.interlace ? cfg.vActive + cnt_t'(1) : cfg.vbStart;
    blkEnd   = cfg.interlace ? cfg.vTotal : cfg.vbEnd;
    if (hCount == cfg.fhEnd)        fpHsNext = 1'b0;
    else if (hCount == cfg.fhStart) fpHsNext = 1'b1;
    else                            fpHsNext = fpHSync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
      field  <= 1'b0;
    end else begin
      hCount <= strb.pixWrap ? '0 : hCount + cnt_t'(1);
      if (strb.lineStep) vCount <= strb.frameWrap ? '0 : vCount + cnt_t'(1);
      if (strb.frameWrap) field <= cfg.interlace && !field;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vBlank  <= 1'b0;
      vSync   <= 1'b0;
      fpHSync <= 1'b0;
      fpVsInt <= 1'b0;
      fpVSync <= 1'b0;
      active  <= 1'b0;
    end else begin
      if (vCount == blkEnd)          vBlank <= 1'b0;
      else if (vCount == blkStart)   vBlank <= 1'b1;
      if (vCount == cfg.vsEnd)       vSync <= 1'b0;
      else if (vCount == cfg.vsStart) vSync <= 1'b1;
      if (vCount == cfg.fvEnd)       fpVsInt <= 1'b0;
      else if (vCount == cfg.fvStart) fpVsInt <= 1'b1;
      fpHSync <= fpHsNext;
      if (fpHsNext && !fpHSync) fpVSync <= fpVsInt;
      active <= (hCount <= cfg.hActive) && (vCount <= cfg.vActive);
    end
  end
endmodule

// File: rtl/dtg_top.sv
module dtg_top
  import dtg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrStart,
  input  logic [CNT_W-1:0]  wrEnd,
  input  logic              lock,
  output logic [CNT_W-1:0]  hCount,
  output logic [CNT_W-1:0]  vCount,
  output logic              field,
  output logic              vBlank,
  output logic              vSync,
  output logic              fpHSync,
  output logic              fpVSync,
  output logic              active
);
  dtg_cfg_t    cfg;
  dtg_strobe_t strb;

  dtg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrStart(wrStart), .wrEnd(wrEnd), .lock(lock), .cfg(cfg)
  );

  dtg_ctrl u_ctrl (
    .cfg(cfg), .hCount(hCount), .vCount(vCount), .strb(strb)
  );

  dtg_datapath u_dp (
    .clk(clk), .rst(rst), .cfg(cfg), .strb(strb),
    .hCount(hCount), .vCount(vCount), .field(field),
    .vBlank(vBlank), .vSync(vSync), .fpHSync(fpHSync),
    .fpVSync(fpVSync), .active(active)
  );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
  import dtg_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     lock,
  input dtg_cfg_t cfg,
  input cnt_t     hCount,
  input cnt_t     vCount,
  input logic     field,
  input logic     vBlank,
  input logic     vSync,
  input logic     fpHSync,
  input logic     fpVSync,
  input logic     active
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (hCount == '0 && vCount == '0 && !field && !vBlank && !vSync &&
             !fpHSync && !fpVSync && !active)); // R1

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(cfg)); // R3

  AST_HCNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (hCount != '0) |-> (hCount == $past(hCount) + cnt_t'(1))); // R4

  AST_VCNT_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(vCount) |-> $past(hCount >= cfg.hTotal ||
                              (cfg.interlace && hCount == (cfg.hTotal >> 1)))); // R10

  AST_FIELD_ONLY_INTERLACED: assert property (@(posedge clk) disable iff (rst)
    $rose(field) |-> $past(cfg.interlace)); // R10

  AST_FPV_ON_HS_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(fpVSync) |-> $rose(fpHSync)); // R8

  AST_ACTIVE_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> $past(hCount <= cfg.hActive && vCount <= cfg.vActive)); // R9
endmodule

bind dtg_top dtg_checker u_chk (
  .clk(clk), .rst(rst), .lock(lock), .cfg(cfg),
  .hCount(hCount), .vCount(vCount), .field(field),
  .vBlank(vBlank), .vSync(vSync), .fpHSync(fpHSync),
  .fpVSync(fpVSync), .active(active)
);

// File: tb/dtg_top_bench.sv
module dtg_top_bench;
  import dtg_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, wrEn = 1'b0, lock = 1'b0;
  logic [2:0] wrAddr = '0;
  cnt_t wrStart = '0, wrEnd = '0;
  cnt_t hCount, vCount;
  logic field, vBlank, vSync, fpHSync, fpVSync, active;

  dtg_top u_dtg_top (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrStart(wrStart), .wrEnd(wrEnd), .lock(lock),
    .hCount(hCount), .vCount(vCount), .field(field), .vBlank(vBlank),
    .vSync(vSync), .fpHSync(fpHSync), .fpVSync(fpVSync), .active(active)
  );

  int nChk = 0, nBad = 0;
  bit done = 0;

  // Reference state built from the requirements
  cnt_t sHT, sHA, sFS, sFE, sVT, sVA, sBS, sBE, sSS, sSE, sPS, sPE;
  logic sIL;
  cnt_t mH, mV;
  logic mF, mVb, mVs, mFh, mFvi, mFv, mAct;
  logic pw, st, fw, fhN;
  cnt_t bs, be;

  always @(posedge clk) begin
    if (rst) begin
      {sHT, sHA, sFS, sFE, sVT, sVA, sBS, sBE, sSS, sSE, sPS, sPE} <= '0;
      sIL <= 0; mH <= 0; mV <= 0; mF <= 0;
      mVb <= 0; mVs <= 0; mFh <= 0; mFvi <= 0; mFv <= 0; mAct <= 0;
    end else begin
      pw = mH >= sHT;
      st = pw || (sIL && mH == (sHT >> 1) && !pw);
      fw = st && mV >= sVT;
      bs = sIL ? sVA + cnt_t'(1) : sBS;
      be = sIL ? sVT : sBE;
      fhN = (mH == sFE) ? 1'b0 : (mH == sFS) ? 1'b1 : mFh;
      mH <= pw ? '0 : mH + cnt_t'(1);
      if (st) mV <= fw ? '0 : mV + cnt_t'(1);
      if (fw) mF <= sIL ? ~mF : 1'b0;
      mVb <= (mV == be) ? 1'b0 : (mV == bs) ? 1'b1 : mVb;
      mVs <= (mV == sSE) ? 1'b0 : (mV == sSS) ? 1'b1 : mVs;
      mFvi <= (mV == sPE) ? 1'b0 : (mV == sPS) ? 1'b1 : mFvi;
      mFh <= fhN;
      if (fhN && !mFh) mFv <= mFvi;
      mAct <= (mH <= sHA) && (mV <= sVA);
      if (wrEn && !lock) begin
        case (wrAddr)
          3'd0: begin sHA <= wrStart; sHT <= wrEnd; end
          3'd1: begin sFS <= wrStart; sFE <= wrEnd; end
          3'd2: begin sVA <= wrStart; sVT <= wrEnd; end
          3'd3: begin sBS <= wrStart; sBE <= wrEnd; end
          3'd4: begin sSS <= wrStart; sSE <= wrEnd; end
          3'd5: begin sPS <= wrStart; sPE <= wrEnd; end
          3'd6: sIL <= wrStart[0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  logic prevFh = 0, prevFv = 0;

  task automatic compareAll();
    chk("R4", "hCount", int'(hCount), int'(mH));
    chk("R4", "vCount", int'(vCount), int'(mV));
    chk("R10", "field", int'(field), int'(mF));
    chk(sIL ? "R11" : "R5", "vBlank", int'(vBlank), int'(mVb));
    chk("R6", "vSync", int'(vSync), int'(mVs));
    chk("R7", "fpHSync", int'(fpHSync), int'(mFh));
    chk("R8", "fpVSync", int'(fpVSync), int'(mFv));
    chk("R9", "active", int'(active), int'(mAct));
    if (fpVSync != prevFv) chk("R8", "fpVSync moved off hsync rise", int'(fpHSync && !prevFh), 1);
    prevFh = fpHSync;
    prevFv = fpVSync;
  endtask

  task automatic runCompare(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic wr(int addr, int s, int e);
    @(negedge clk);
    wrEn = 1; wrAddr = 3'(addr); wrStart = cnt_t'(s); wrEnd = cnt_t'(e);
    @(negedge clk);
    wrEn = 0;
    compareAll();
  endtask

  task automatic tReset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1", "hCount in reset", int'(hCount), 0);
    chk("R1", "vCount in reset", int'(vCount), 0);
    chk("R1", "outputs in reset",
        int'({field, vBlank, vSync, fpHSync, fpVSync, active}), 0);
    rst = 0;
    @(negedge clk);
    prevFh = fpHSync; prevFv = fpVSync;
  endtask

  task automatic tProgressive();
    wr(0, 13, 19);
    wr(1, 15, 17);
    wr(2, 5, 9);
    wr(3, 6, 9);
    wr(4, 7, 8);
    wr(5, 5, 7);
    runCompare(450);
  endtask

  task automatic tLock();
    int maxH;
    lock = 1;
    wr(0, 3, 5);
    maxH = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      compareAll();
      if (int'(hCount) > maxH) maxH = int'(hCount);
    end
    chk("R3", "max hCount after locked write", maxH, 19);
    lock = 0;
    wr(0, 3, 7);
    maxH = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      compareAll();
      if (int'(hCount) > maxH) maxH = int'(hCount);
    end
    chk("R2", "max hCount after unlocked write", maxH, 7);
    wr(0, 13, 19);
    runCompare(100);
  endtask

  task automatic tInterlace();
    int rises[3];
    int nr;
    logic pv;
    wr(2, 7, 10);
    wr(3, 2, 3);
    wr(4, 9, 10);
    wr(6, 1, 0);
    nr = 0;
    pv = vSync;
    for (int i = 0; i < 900; i++) begin
      @(negedge clk);
      compareAll();
      if (vSync && !pv && nr < 3) begin
        rises[nr] = int'(hCount);
        nr++;
      end
      pv = vSync;
    end
    chk("R12", "vsync rises seen", nr, 3);
    for (int k = 0; k < 2; k++) begin
      chk("R12", "rise position legal", int'(rises[k] == 1 || rises[k] == 11), 1);
      chk("R12", "rise position alternates", int'(rises[k] != rises[k+1]), 1);
    end
    wr(6, 0, 0);
    runCompare(450);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    tReset();
    tProgressive();
    tLock();
    tInterlace();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule